// File: doc/BRIEF.md
# Receive Idle Timeout and Block-End Detector

This block works next to a serial receiver. It measures how long the line stays quiet, in bit times, and it counts received characters so that it can mark the end of a block. A one-cycle `baud_tick` strobe supplies the bit-time base. The receiver supplies a strobe when it sees a start bit and another when it has taken in a whole character. Software writes a threshold and a block length, and it clears the two sticky flags by pulsing the clear inputs.

In the default character mode, the quiet interval is measured from the end of the last received character. A new start bit suspends the measurement until the next character completes. In smartcard mode the interval is measured from the start bit of the last character. The threshold may be changed while a measurement is running. A value at or below the elapsed count fires the flag on the next cycle.

The block length is the number of characters in the block minus one, so the end-of-block flag rises on character number length+1. Outside smartcard mode, the character count is reset by disabling the receiver or by clearing the end-of-block flag. In smartcard mode it is reset only while the transmit buffer is not empty.

Top module: `rx_idle_watch`

## Requirements
- R1: After reset, `to_flag` and `eob_flag` are 0.
- R2: With `sc_mode`=0, `to_flag` becomes 1 on the clock edge after the one on which the count of `baud_tick` pulses since the last `char_done` reaches the threshold. It is still 0 after threshold-1 pulses.
- R3: With `sc_mode`=0, a `start_det` pulse clears and stops the measurement. No `to_flag` is raised, whatever the number of `baud_tick` pulses, until the next `char_done` starts a new measurement.
- R4: With `sc_mode`=1, the measurement restarts on each `start_det`, and `char_done` does not restart it. The flag therefore rises threshold ticks after the last start bit.
- R5: If the threshold is rewritten during a measurement to a value less than or equal to the ticks already counted, `to_flag` becomes 1 on the edge after the write.
- R6: `to_flag` stays 1 until `to_clr` is pulsed. After a timeout, no further timeout is raised until a new reference event restarts the measurement.
- R7: While `rx_en`=0 the tick count is held at zero and the measurement is abandoned. After re-enabling, no timeout occurs until a new reference event.
- R8: `eob_flag` becomes 1 on the clock edge of the `char_done` that brings the character count to block length + 1. It stays 1 until `eob_clr`.
- R9: With `sc_mode`=0, the character count returns to zero when `rx_en`=0 or when `eob_clr` is pulsed.
- R10: With `sc_mode`=1, the character count returns to zero only while `tx_empty`=0. An `eob_clr` pulse lowers the flag but keeps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| rx_en | input | 1 | Receiver enabled |
| sc_mode | input | 1 | 1 selects smartcard timing and count reset rules |
| tx_empty | input | 1 | Transmit buffer empty indication |
| start_det | input | 1 | Start bit seen (one-cycle strobe) |
| char_done | input | 1 | Character received (one-cycle strobe) |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | THR_W | New threshold in bit times |
| blen_we | input | 1 | Block length write strobe |
| blen_val | input | BLEN_W | Block length (characters - 1) |
| to_clr | input | 1 | Clear timeout flag |
| eob_clr | input | 1 | Clear end-of-block flag |
| to_flag | output | 1 | Sticky receive timeout flag |
| eob_flag | output | 1 | Sticky end-of-block flag |

## Verification
The timer is driven with a quiet line after a character, both one tick short of and exactly at the threshold. This pins down the firing edge. Runs with an intervening start bit, with the receiver disabled mid-count, and in smartcard mode where a character completes partway through separate the two reference points and show that a disabled or suspended measurement cannot fire. Threshold rewrites below and equal to the elapsed count show the immediate-fire path. Character trains of length+1 under each reset source (receiver disable, flag clear, transmit-busy) show which events restart the block count in each mode.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
   // which receiver event opens a new idle measurement
   typedef enum logic {
      REF_CHAR_END  = 1'b0,
      REF_START_BIT = 1'b1
   } rxw_ref_e;

   localparam int unsigned RXW_THR_W_MAX  = 32;
   localparam int unsigned RXW_BLEN_W_MAX = 16;
endpackage

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer #(
   parameter int unsigned THR_W    = 24,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             rx_en,
   input  logic             restart,
   input  logic             suspend,
   input  logic             thr_we,
   input  logic [THR_W-1:0] thr_val,
   input  logic             flag_clr,
   output logic             flag
);
   localparam logic [THR_W-1:0] CNT_MAX = '1;

   if (THR_W < 2 || THR_W > rxw_pkg::RXW_THR_W_MAX) begin : g_bad_thr_w
      $error("rxw_idle_timer: THR_W out of range");
   end

   logic [THR_W-1:0] thr_q;
   logic [THR_W-1:0] cnt_q;
   logic             armed_q;
   logic             hit;

   assign hit = rx_en && armed_q && !restart && !suspend && (cnt_q >= thr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      thr_q <= '0;
      else if (thr_we) thr_q <= thr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!rx_en) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (restart) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (suspend) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (hit) begin
         armed_q <= 1'b0;
      end else if (armed_q && baud_tick && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (SET_WINS) begin : g_set_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag <= 1'b0;
         else if (hit)      flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end else begin : g_clr_first
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag <= 1'b0;
         else if (flag_clr) flag <= 1'b0;
         else if (hit)      flag <= 1'b1;
      end
   end

   // R7: a disabled receiver leaves no count behind
   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (cnt_q == '0 && !armed_q));
   // R6: flag is sticky without a clear
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
   // R7: a timeout only rises while the receiver was enabled
   a_r7_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(rx_en));
   // R3: a suspended measurement holds no count
   a_r3_suspend_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (suspend && !restart) |=> (cnt_q == '0));
endmodule

// File: rtl/rxw_block_counter.sv
module rxw_block_counter #(
   parameter int unsigned BLEN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sc_mode,
   input  logic              rx_en,
   input  logic              tx_empty,
   input  logic              char_done,
   input  logic              blen_we,
   input  logic [BLEN_W-1:0] blen_val,
   input  logic              eob_clr,
   output logic              eob
);
   localparam int unsigned CW = BLEN_W + 1;
   localparam logic [CW-1:0] BCNT_MAX = '1;

   if (BLEN_W < 1 || BLEN_W > rxw_pkg::RXW_BLEN_W_MAX) begin : g_bad_blen_w
      $error("rxw_block_counter: BLEN_W out of range");
   end

   logic [BLEN_W-1:0] blen_q;
   logic [CW-1:0]     bcnt_q;
   logic              cnt_rst;
   logic              last_char;

   assign cnt_rst   = sc_mode ? !tx_empty : (!rx_en || eob_clr);
   assign last_char = char_done && !cnt_rst && (bcnt_q == {1'b0, blen_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       blen_q <= '0;
      else if (blen_we) blen_q <= blen_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bcnt_q <= '0;
      else if (cnt_rst)                          bcnt_q <= '0;
      else if (char_done && bcnt_q != BCNT_MAX)  bcnt_q <= bcnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         eob <= 1'b0;
      else if (last_char) eob <= 1'b1;
      else if (eob_clr)   eob <= 1'b0;
   end

   // R8: end-of-block flag holds until cleared
   a_r8_eob_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (eob && !eob_clr) |=> eob);
   // R8: the flag rises only on a received character
   a_r8_eob_on_char: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eob) |-> $past(char_done));
   // R9: normal-mode reset sources empty the count
   a_r9_norm_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (!sc_mode && (!rx_en || eob_clr)) |=> (bcnt_q == '0));
   // R10: transmit-busy empties the count in smartcard mode
   a_r10_sc_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_mode && !tx_empty) |=> (bcnt_q == '0));
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
   parameter int unsigned THR_W    = 24,
   parameter int unsigned BLEN_W   = 8,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              rx_en,
   input  logic              sc_mode,
   input  logic              tx_empty,
   input  logic              start_det,
   input  logic              char_done,
   input  logic              thr_we,
   input  logic [THR_W-1:0]  thr_val,
   input  logic              blen_we,
   input  logic [BLEN_W-1:0] blen_val,
   input  logic              to_clr,
   input  logic              eob_clr,
   output logic              to_flag,
   output logic              eob_flag
);
   import rxw_pkg::*;

   rxw_ref_e ref_sel;
   logic     restart;
   logic     suspend;

   assign ref_sel = sc_mode ? REF_START_BIT : REF_CHAR_END;
   assign restart = (ref_sel == REF_START_BIT) ? start_det : char_done;
   assign suspend = (ref_sel == REF_CHAR_END) && start_det;

   rxw_idle_timer #(.THR_W(THR_W), .SET_WINS(SET_WINS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .rx_en     (rx_en),
      .restart   (restart),
      .suspend   (suspend),
      .thr_we    (thr_we),
      .thr_val   (thr_val),
      .flag_clr  (to_clr),
      .flag      (to_flag)
   );

   rxw_block_counter #(.BLEN_W(BLEN_W)) u_block (
      .clk       (clk),
      .rst_n     (rst_n),
      .sc_mode   (sc_mode),
      .rx_en     (rx_en),
      .tx_empty  (tx_empty),
      .char_done (char_done),
      .blen_we   (blen_we),
      .blen_val  (blen_val),
      .eob_clr   (eob_clr),
      .eob       (eob_flag)
   );
endmodule

// File: tb/sim_rx_idle_watch.sv
module sim_rx_idle_watch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        baud_tick = 1'b0, rx_en = 1'b1, sc_mode = 1'b0, tx_empty = 1'b1;
   logic        start_det = 1'b0, char_done = 1'b0, thr_we = 1'b0, blen_we = 1'b0;
   logic [23:0] thr_val = '0;
   logic [7:0]  blen_val = '0;
   logic        to_clr = 1'b0, eob_clr = 1'b0;
   logic        to_flag, eob_flag;
   int          checks = 0, errors = 0;

   always #4 clk = ~clk;

   rx_idle_watch u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
      .sc_mode(sc_mode), .tx_empty(tx_empty), .start_det(start_det),
      .char_done(char_done), .thr_we(thr_we), .thr_val(thr_val),
      .blen_we(blen_we), .blen_val(blen_val), .to_clr(to_clr),
      .eob_clr(eob_clr), .to_flag(to_flag), .eob_flag(eob_flag)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) baud_tick = 1'b1;
         @(negedge clk) baud_tick = 1'b0;
      end
   endtask

   task automatic p_char();  @(negedge clk) char_done = 1'b1; @(negedge clk) char_done = 1'b0; endtask
   task automatic p_start(); @(negedge clk) start_det = 1'b1; @(negedge clk) start_det = 1'b0; endtask
   task automatic p_toclr(); @(negedge clk) to_clr = 1'b1;    @(negedge clk) to_clr = 1'b0;    endtask
   task automatic p_eobclr();@(negedge clk) eob_clr = 1'b1;   @(negedge clk) eob_clr = 1'b0;   endtask

   task automatic set_thr(input int v);
      @(negedge clk) begin thr_val = 24'(v); thr_we = 1'b1; end
      @(negedge clk) thr_we = 1'b0;
   endtask

   task automatic set_blen(input int v);
      @(negedge clk) begin blen_val = 8'(v); blen_we = 1'b1; end
      @(negedge clk) blen_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 to_flag", to_flag, 1'b0);
      chk("R1 eob_flag", eob_flag, 1'b0);
   endtask

   task automatic t_normal_timeout();
      set_thr(5); p_toclr(); p_char();
      ticks(4); idle(1);
      chk("R2 before threshold", to_flag, 1'b0);
      ticks(1); idle(1);
      chk("R2 at threshold", to_flag, 1'b1);
   endtask

   task automatic t_sticky();
      idle(3);
      chk("R6 held", to_flag, 1'b1);
      p_toclr(); ticks(8); idle(1);
      chk("R6 no refire after clear", to_flag, 1'b0);
      p_char(); ticks(5); idle(1);
      chk("R6 refire after new char", to_flag, 1'b1);
      p_toclr();
   endtask

   task automatic t_start_suspends();
      p_char(); ticks(3); p_start(); ticks(10); idle(1);
      chk("R3 suspended by start bit", to_flag, 1'b0);
      p_char(); ticks(5); idle(1);
      chk("R3 resumes on next char", to_flag, 1'b1);
      p_toclr();
   endtask

   task automatic t_smartcard();
      sc_mode = 1'b1;
      p_start(); ticks(3); p_char(); ticks(1); idle(1);
      chk("R4 not yet", to_flag, 1'b0);
      ticks(1); idle(1);
      chk("R4 measured from start bit", to_flag, 1'b1);
      p_toclr(); p_char(); ticks(8); idle(1);
      chk("R4 char does not restart", to_flag, 1'b0);
      sc_mode = 1'b0; p_toclr();
   endtask

   task automatic t_rewrite();
      set_thr(20); p_char(); ticks(8); idle(1);
      chk("R5 before rewrite", to_flag, 1'b0);
      set_thr(6); idle(1);
      chk("R5 rewrite below count", to_flag, 1'b1);
      p_toclr(); set_thr(20); p_char(); ticks(8);
      set_thr(8); idle(1);
      chk("R5 rewrite equal count", to_flag, 1'b1);
      p_toclr(); set_thr(5);
   endtask

   task automatic t_disable();
      p_char(); ticks(2);
      @(negedge clk) rx_en = 1'b0;
      ticks(10); idle(1);
      chk("R7 disabled no timeout", to_flag, 1'b0);
      @(negedge clk) rx_en = 1'b1;
      ticks(10); idle(1);
      chk("R7 re-enabled still idle", to_flag, 1'b0);
   endtask

   task automatic t_block_normal();
      set_blen(2); p_eobclr();
      p_char(); p_char();
      chk("R8 two chars", eob_flag, 1'b0);
      p_char();
      chk("R8 third char", eob_flag, 1'b1);
      p_char(); idle(2);
      chk("R8 sticky", eob_flag, 1'b1);
      p_eobclr();
      chk("R9 clear lowers flag", eob_flag, 1'b0);
      p_char(); p_char();
      chk("R9 count restarted by clear", eob_flag, 1'b0);
      p_char();
      chk("R9 block after clear", eob_flag, 1'b1);
      p_eobclr(); p_char(); p_char();
      @(negedge clk) rx_en = 1'b0;
      @(negedge clk) rx_en = 1'b1;
      p_char(); p_char();
      chk("R9 count restarted by disable", eob_flag, 1'b0);
      p_char();
      chk("R9 block after disable", eob_flag, 1'b1);
      p_eobclr();
   endtask

   task automatic t_block_sc();
      sc_mode = 1'b1;
      @(negedge clk) tx_empty = 1'b0;
      @(negedge clk) tx_empty = 1'b1;
      p_char(); p_char(); p_eobclr(); p_char();
      chk("R10 clear keeps count", eob_flag, 1'b1);
      p_eobclr();
      @(negedge clk) tx_empty = 1'b0;
      @(negedge clk) tx_empty = 1'b1;
      p_char(); p_char();
      chk("R10 tx busy reset count", eob_flag, 1'b0);
      p_char();
      chk("R10 block after tx reset", eob_flag, 1'b1);
      sc_mode = 1'b0; p_eobclr();
   endtask

   initial begin
      idle(3);
      @(negedge clk) rst_n = 1'b1;
      idle(1);
      t_reset();
      t_normal_timeout();
      t_sticky();
      t_start_suspends();
      t_smartcard();
      t_rewrite();
      t_disable();
      t_block_normal();
      t_block_sc();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule